// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Holding Register

This block accepts a bit stream on a serial data input. Each rising edge of a shift strobe moves the stream one place along a shift chain. A second strobe copies the whole chain at once into a separate holding register, whose contents drive the parallel outputs. Because the chain and the holding register are separate, a new word can be shifted in while the previous word stays steady on the parallel outputs.

Both strobes are treated as asynchronous signals. They are synchronized into the system clock and edge-detected, so every register in the block is clocked by the system clock alone. The serial data input passes through the same synchronizer, so each bit stays aligned with its strobe.

An active-low clear empties the shift chain at once and leaves the holding register alone. An active-low output enable gives each parallel bit a drive-enable signal that a pad wrapper can turn into a tri-state buffer. The top stage of the chain drives a serial output that is always driven. Wiring that output to the serial input of a second copy, with the strobes shared, builds a wider register.

Top module: `sipo_latch_reg`

## Requirements
- R1: A detected shift edge loads the synchronized serial input into stage 0 and moves each stage k into stage k+1. The old top stage (stage WIDTH-1) is discarded. Stage 0 is bit 0 of `par_q` once latched.
- R2: A detected latch edge copies every shift stage into the holding register in the same cycle. `par_q` then shows the holding register.
- R3: Driving `clr_n` low clears the whole shift chain without waiting for a clock edge. The holding register keeps its value.
- R4: When `oe_n` is 0, every bit of `par_oe` is 1 (drive). When `oe_n` is 1, every bit of `par_oe` is 0 (high impedance). `par_q` keeps carrying the holding register either way.
- R5: `ser_out` always equals the top shift stage, whatever the level of `oe_n`.
- R6: While `clr_n` is low, `ser_out` is 0.
- R7: Without a detected shift edge the shift chain holds its value. Without a detected latch edge the holding register holds its value. A strobe held high counts as one edge only.
- R8: If a shift edge and a latch edge are detected in the same cycle, the holding register captures the chain as it was before that shift.
- R9: A strobe rising between clock edges takes effect at the third rising clock edge after it. Before that edge the affected register still shows its old value.
- R10: While `rst_n` is low at a rising clock edge, the synchronizers, the shift chain and the holding register are all cleared.
- R11: After `clr_n` returns high, the shift chain stays clear through the next rising clock edge. Shifting resumes once the internal clear has been released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr_n | input | 1 | Active-low clear of the shift chain (asynchronous assert) |
| ser_in | input | 1 | Serial data input |
| shift_strb | input | 1 | Shift strobe, acts on its rising edge |
| latch_strb | input | 1 | Latch strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low parallel output enable |
| par_q | output | WIDTH | Holding register contents (tri-state data) |
| par_oe | output | WIDTH | Per-bit drive enable for `par_q`, 1 = drive |
| ser_out | output | 1 | Top shift stage, never tri-stated |

## Verification
Shift and latch results appear at the third rising clock edge after the strobe rises. The bench therefore keeps each strobe high for two clock cycles, then waits three more falling edges before it samples. One directed test samples the holding register just after the second edge and again just after the third, to pin down that latency. The clear and the output enable act without a clock, so their effects are sampled 2 ns after the change, before any clock edge. The bench cascades two copies and holds each serial bit for a full cycle before its strobe, which keeps the data aligned with the strobe through the second copy's synchronizer.

// File: rtl/sipo_pkg.sv
// Shared constants and types for the serial-in register with holding stage.
// Assumes nothing beyond a single system clock domain.
package sipo_pkg;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_SYNC  = 2;
    localparam int CLR_SYNC  = 2;

    typedef struct packed {
        logic shift;
        logic latch;
    } strobe_ev_t;
endpackage

// File: rtl/sync_chain.sv
// Multi-lane flop synchronizer for asynchronous inputs.
// Assumes each lane is independent; STAGES >= 1.
module sync_chain #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    logic [LANES-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // capture raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end
        end else begin : g_next
            // pass along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/clr_sync.sv
// Clear conditioner: asserts at once when clr_n falls and releases
// only after STAGES clock edges with clr_n high.
module clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic clr_int_n
);
    logic [STAGES-1:0] rel;

    // asynchronous assert, clocked release
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) rel <= '0;
        else        rel <= {rel[STAGES-2:0], 1'b1};
    end

    assign clr_int_n = rel[STAGES-1];
endmodule

// File: rtl/shift_stage.sv
// Shift chain: shifts toward the top bit on shift_en.
// Assumes WIDTH >= 2; clr_int_n is clock-released.
module shift_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_int_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    assign nxt = {q[WIDTH-2:0], din};

    // chain update with asynchronous clear
    always_ff @(posedge clk or negedge clr_int_n) begin
        if (!clr_int_n)   q <= '0;
        else if (!rst_n)  q <= '0;
        else if (shift_en) q <= nxt;
    end
endmodule

// File: rtl/store_stage.sv
// Holding register: parallel load on load, otherwise holds.
// Not touched by the shift-chain clear.
module store_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // parallel capture
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sipo_latch_reg.sv
// Serial-in shift register with separate holding register.
// Strobes and serial data are synchronized and edge-detected on clk;
// par_q / par_oe feed an external tri-state pad wrapper.
module sipo_latch_reg
    import sipo_pkg::*;
#(
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             shift_strb,
    input  logic             latch_strb,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_q,
    output logic [WIDTH-1:0] par_oe,
    output logic             ser_out
);
    logic [2:0]       raw_in;
    logic [2:0]       synced;
    logic [1:0]       strb_prev;
    strobe_ev_t       ev;
    logic             shift_pls;
    logic             latch_pls;
    logic             clr_int_n;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] store_q;

    assign raw_in = {latch_strb, shift_strb, ser_in};

    sync_chain #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    // remember last synchronized strobe levels
    always_ff @(posedge clk) begin
        if (!rst_n) strb_prev <= '0;
        else        strb_prev <= synced[2:1];
    end

    assign ev.shift = synced[1] & ~strb_prev[0];
    assign ev.latch = synced[2] & ~strb_prev[1];
    assign shift_pls = ev.shift;
    assign latch_pls = ev.latch;

    clr_sync #(.STAGES(CLR_SYNC)) u_clr (
        .clk      (clk),
        .clr_n    (clr_n),
        .clr_int_n(clr_int_n)
    );

    shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_int_n(clr_int_n),
        .shift_en (shift_pls),
        .din      (synced[0]),
        .q        (shift_q)
    );

    store_stage #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .load (latch_pls),
        .d    (shift_q),
        .q    (store_q)
    );

    assign par_q   = store_q;
    assign par_oe  = {WIDTH{~oe_n}};
    assign ser_out = shift_q[WIDTH-1];
endmodule

// File: rtl/sipo_latch_reg_chk.sv
// Property checker for sipo_latch_reg, attached by bind.
module sipo_latch_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             clr_int_n,
    input logic             ser_out,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] store_q,
    input logic             shift_pls,
    input logic             latch_pls
);
    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_int_n && shift_pls) |=> (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])));

    // R2
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pls |=> (store_q == $past(shift_q)));

    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_int_n && !shift_pls) |=> $stable(shift_q));

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pls |=> $stable(store_q));

    // R6
    ser_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !ser_out);

    // R11
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n) |=> (shift_q == '0));
endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .clr_int_n(clr_int_n),
    .ser_out  (ser_out),
    .shift_q  (shift_q),
    .store_q  (store_q),
    .shift_pls(shift_pls),
    .latch_pls(latch_pls)
);

// File: tb/sipo_latch_reg_tb.sv
// Bench: two cascaded copies form a 16-bit register.
module sipo_latch_reg_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic ser_in = 1'b0;
    logic shift_strb = 1'b0;
    logic latch_strb = 1'b0;
    logic oe_n = 1'b0;
    logic [W-1:0] par_q1, par_oe1, par_q2, par_oe2;
    logic ser1, ser2;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sipo_latch_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_in),
        .shift_strb(shift_strb), .latch_strb(latch_strb), .oe_n(oe_n),
        .par_q(par_q1), .par_oe(par_oe1), .ser_out(ser1)
    );

    sipo_latch_reg #(.WIDTH(W)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser1),
        .shift_strb(shift_strb), .latch_strb(latch_strb), .oe_n(oe_n),
        .par_q(par_q2), .par_oe(par_oe2), .ser_out(ser2)
    );

    // entry: {oe_n, 16-bit word}
    localparam logic [16:0] VEC [5] = '{
        {1'b0, 16'hA5C3}, {1'b1, 16'h3C5A}, {1'b0, 16'h0001},
        {1'b0, 16'h8000}, {1'b1, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic s, input logic l);
        @(negedge clk);
        shift_strb = s;
        latch_strb = l;
        repeat (2) @(negedge clk);
        shift_strb = 1'b0;
        latch_strb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        pulse(1'b1, 1'b0);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset par_q", {par_q2, par_q1}, 16'h0000);
        chk("R10 reset ser_out", {ser2, ser1}, 2'b00);
        chk("R4 reset par_oe", {par_oe2, par_oe1}, 16'hFFFF);

        prev = 16'h0000;
        for (int v = 0; v < 5; v++) begin
            oe_n = VEC[v][16];
            shift_word(VEC[v][15:0]);
            // R7 holding register untouched by shifting
            chk("R7 hold before latch", {par_q2, par_q1}, prev);
            // R5 serial taps of both copies
            chk("R5 ser_out taps", {ser2, ser1}, {VEC[v][15], VEC[v][7]});
            pulse(1'b0, 1'b1);
            // R1 R2 cascaded transfer
            chk("R1/R2 word", {par_q2, par_q1}, VEC[v][15:0]);
            chk("R4 par_oe", {par_oe2, par_oe1}, VEC[v][16] ? 16'h0000 : 16'hFFFF);
            prev = VEC[v][15:0];
        end
        oe_n = 1'b0;

        // R9 latency of a latch strobe
        shift_word(16'h9281);
        @(negedge clk);
        latch_strb = 1'b1;
        @(posedge clk); @(posedge clk); #5;
        chk("R9 old value after 2 edges", {par_q2, par_q1}, prev);
        @(posedge clk); #5;
        chk("R9 new value after 3 edges", {par_q2, par_q1}, 16'h9281);
        @(negedge clk);
        latch_strb = 1'b0;
        repeat (3) @(negedge clk);

        // R3 R6 asynchronous clear
        chk("R5 ser_out before clear", {ser2, ser1}, 2'b11);
        clr_n = 1'b0;
        #2;
        chk("R6 ser_out low in clear", {ser2, ser1}, 2'b00);
        chk("R3 store kept in clear", {par_q2, par_q1}, 16'h9281);
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse(1'b0, 1'b1);
        chk("R3 chain cleared", {par_q2, par_q1}, 16'h0000);

        // R11 shifting resumes after release
        shift_bit(1'b1);
        pulse(1'b0, 1'b1);
        chk("R11 resume shift", {par_q2, par_q1}, 16'h0001);

        // R8 simultaneous shift and latch
        @(negedge clk);
        ser_in = 1'b1;
        pulse(1'b1, 1'b1);
        chk("R8 pre-shift capture", {par_q2, par_q1}, 16'h0001);
        pulse(1'b0, 1'b1);
        chk("R8 shift done", {par_q2, par_q1}, 16'h0003);

        // R7 held strobe is a single edge
        @(negedge clk);
        ser_in = 1'b0;
        @(negedge clk);
        shift_strb = 1'b1;
        repeat (20) @(negedge clk);
        shift_strb = 1'b0;
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1);
        chk("R7 held strobe one shift", {par_q2, par_q1}, 16'h0006);

        // R4 R5 output enable toggling
        oe_n = 1'b1;
        #2;
        chk("R4 oe high tri-state", {par_oe2, par_oe1}, 16'h0000);
        chk("R4 data kept", {par_q2, par_q1}, 16'h0006);
        chk("R5 ser_out unaffected", {ser2, ser1}, 2'b00);
        @(negedge clk);
        oe_n = 1'b0;
        #2;
        chk("R4 oe low drive", {par_oe2, par_oe1}, 16'hFFFF);

        // R10 reset mid-run clears holding register
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 store cleared", {par_q2, par_q1}, 16'h0000);

        finish_run();
    end
endmodule